// File: doc/BRIEF.md
# Command-Processor Integer ALU

This block is the arithmetic unit of a small microcontroller that sequences commands inside a larger chip. Each cycle it can accept one 32-bit instruction word and two 32-bit operand values that the register file has already read. It decodes the instruction, performs one integer operation and registers a 32-bit result. A single carry flag is kept inside the block. It lets two 32-bit halves be chained into a 64-bit add or subtract.

An instruction word takes one of two forms. In the register form, the top five bits hold a fixed marker and the low five bits pick the operation. In the immediate form, the top five bits pick the operation, and a 16-bit constant, zero-extended, takes the place of the second operand. The operations are:

- add and subtract, each with a high-half variant
- bitwise AND, OR, XOR and NOT
- three shifts and a left rotate
- an 8x8 multiply
- unsigned minimum and maximum
- a three-way compare that returns bit-pattern codes meant for branch-on-bit tests
- a leading-one index

Top module: `cp_alu`

## Requirements
- R1: When `valid_i` is 1, the operation is chosen from `instr_i`. If bits 31:27 equal 5'b10011 (register form), the operation code is bits 4:0 and the second operand is `src2_i`. Otherwise (immediate form), the operation code is bits 31:27 and the second operand is bits 15:0 zero-extended. The result appears on `result_o` with `result_valid_o` high exactly one cycle later. `result_o` holds its value while no instruction is issued.
- R2: Code 1 (add) gives src1+b and sets the carry flag to the carry out. Code 2 (add-high) gives src1+b+carry and leaves the flag unchanged.
- R3: Code 3 (subtract) gives src1-b and sets the carry flag to 1 exactly when src1<b unsigned, which is a borrow. Code 4 (subtract-high) gives src1-b-carry and leaves the flag unchanged.
- R4: Codes 5, 6 and 7 give the bitwise AND, OR and XOR of src1 and b. An OR whose src1 is zero returns b unchanged, which is how a move is performed.
- R5: Code 8 gives the bitwise inverse of the second operand b. In the register form that operand is `src2_i`.
- R6: Codes 9, 10 and 11 shift src1 by b[4:0]. Code 9 shifts left. Code 10 shifts right and fills with zeros. Code 11 shifts right and fills with copies of bit 31.
- R7: Code 12 rotates src1 left by b[4:0]; bits leaving bit 31 re-enter at bit 0.
- R8: Code 13 gives the product of src1[7:0] and b[7:0] as a 16-bit value, zero-extended to 32 bits.
- R9: Code 14 gives the unsigned minimum of src1 and b. Code 15 gives the unsigned maximum.
- R10: Code 16 compares src1 and b unsigned. It gives 32'h00 when src1>b, 32'h2b when they are equal, and 32'h1e when src1<b.
- R11: Code 20 exists only in the register form. It gives the bit index of the highest set bit of b, or 0 when b is zero.
- R12: The carry flag is 0 after reset. Only codes 1 and 3 change it. Cycles with `valid_i` low leave it unchanged.
- R13: An undefined operation gives a result of 0 and leaves the carry flag unchanged. Undefined means register-form code 0, 17-19 or 21-31, or immediate-form code 0, 17-18 or 20-31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Issue strobe for the instruction on `instr_i` |
| instr_i | input | 32 | Instruction word |
| src1_i | input | 32 | First operand value |
| src2_i | input | 32 | Second operand value (used in register form) |
| result_o | output | 32 | Registered result |
| result_valid_o | output | 1 | High for one cycle when `result_o` carries a new result |
| carry_o | output | 1 | Current carry/borrow flag |

## Verification
The bench targets the edges where carry and borrow go wrong:

- **All-ones plus one.** This sum must wrap to zero and raise the flag. A design that drops the carry out would then leave the 64-bit high half one too small.
- **Subtracts that do and do not borrow, each followed by a high-half subtract.** Inverting the borrow sense shifts every 64-bit difference by one.

Shift and rotate amounts above 31 are applied to catch a design that uses more than five bits, which would return zero instead of a shifted value. A negative value shifted arithmetically catches a design that fills with zeros. Compare, min and max run with all-ones against one, so a signed comparison shows up as swapped codes. Undefined codes placed between carry-setting operations expose any design that writes the flag or returns stale data for them.

// File: rtl/cpalu_pkg.sv
package cpalu_pkg;

    localparam int INSTR_W = 32;
    localparam logic [4:0] REG_FORM = 5'b10011;

    typedef enum logic [4:0] {
        OP_BAD   = 5'd0,
        OP_ADD   = 5'd1,
        OP_ADDHI = 5'd2,
        OP_SUB   = 5'd3,
        OP_SUBHI = 5'd4,
        OP_AND   = 5'd5,
        OP_OR    = 5'd6,
        OP_XOR   = 5'd7,
        OP_NOT   = 5'd8,
        OP_SHL   = 5'd9,
        OP_USHR  = 5'd10,
        OP_ISHR  = 5'd11,
        OP_ROT   = 5'd12,
        OP_MUL8  = 5'd13,
        OP_MIN   = 5'd14,
        OP_MAX   = 5'd15,
        OP_CMP   = 5'd16,
        OP_MSB   = 5'd20
    } alu_op_e;

    localparam logic [7:0] CMP_GT = 8'h00;
    localparam logic [7:0] CMP_EQ = 8'h2b;
    localparam logic [7:0] CMP_LT = 8'h1e;

    function automatic logic is_reg_form(logic [INSTR_W-1:0] instr);
        return instr[INSTR_W-1:INSTR_W-5] == REG_FORM;
    endfunction

    function automatic alu_op_e op_of(logic [INSTR_W-1:0] instr);
        logic       regf;
        logic [4:0] code;
        regf = is_reg_form(instr);
        code = regf ? instr[4:0] : instr[INSTR_W-1:INSTR_W-5];
        if (code >= 5'd1 && code <= 5'd16)
            return alu_op_e'(code);
        else if (regf && code == 5'd20)
            return OP_MSB;
        else
            return OP_BAD;
    endfunction

    function automatic logic writes_carry(alu_op_e op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

endpackage

// File: rtl/cpalu_decode.sv
module cpalu_decode
    import cpalu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [INSTR_W-1:0] instr,
    input  logic [DATA_W-1:0]  src2,
    output alu_op_e            op,
    output logic [DATA_W-1:0]  opb
);
    logic [DATA_W-1:0] imm_ext;

    generate
        if (IMM_W < DATA_W) begin : g_pad
            assign imm_ext = {{(DATA_W-IMM_W){1'b0}}, instr[IMM_W-1:0]};
        end else begin : g_nopad
            assign imm_ext = instr[DATA_W-1:0];
        end
    endgenerate

    always_comb begin
        op  = op_of(instr);
        opb = is_reg_form(instr) ? src2 : imm_ext;
    end
endmodule

// File: rtl/cpalu_addsub.sv
module cpalu_addsub
    import cpalu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    output logic [DATA_W-1:0] sum,
    output logic              cout
);
    logic [DATA_W:0] wide;
    logic [DATA_W:0] cin_ext;

    assign cin_ext = {{DATA_W{1'b0}}, cin};

    always_comb begin
        wide = '0;
        cout = cin;
        unique case (op)
            OP_ADD: begin
                wide = {1'b0, a} + {1'b0, b};
                cout = wide[DATA_W];
            end
            OP_ADDHI: wide = {1'b0, a} + {1'b0, b} + cin_ext;
            OP_SUB: begin
                wide = {1'b0, a} - {1'b0, b};
                cout = (a < b);
            end
            OP_SUBHI: wide = {1'b0, a} - {1'b0, b} - cin_ext;
            default: wide = '0;
        endcase
        sum = wide[DATA_W-1:0];
    end
endmodule

// File: rtl/cpalu_shift.sv
module cpalu_shift
    import cpalu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res
);
    localparam int SHAMT_W = $clog2(DATA_W);

    logic [SHAMT_W-1:0]  amt;
    logic [2*DATA_W-1:0] dbl;

    assign amt = b[SHAMT_W-1:0];
    assign dbl = {a, a} << amt;

    always_comb begin
        unique case (op)
            OP_SHL:  res = a << amt;
            OP_USHR: res = a >> amt;
            OP_ISHR: res = $signed(a) >>> amt;
            OP_ROT:  res = dbl[2*DATA_W-1:DATA_W];
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/cpalu_misc.sv
module cpalu_misc
    import cpalu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int MUL_W  = 8
) (
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] res
);
    localparam int IDX_W = $clog2(DATA_W);

    logic [2*MUL_W-1:0] prod;
    logic [IDX_W-1:0]   top_idx;
    logic [7:0]         cmp_code;

    assign prod = a[MUL_W-1:0] * b[MUL_W-1:0];

    always_comb begin
        top_idx = '0;
        for (int i = 0; i < DATA_W; i++) begin
            if (b[i]) top_idx = IDX_W'(i);
        end
    end

    always_comb begin
        if (a > b)       cmp_code = CMP_GT;
        else if (a == b) cmp_code = CMP_EQ;
        else             cmp_code = CMP_LT;
    end

    always_comb begin
        unique case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_NOT:  res = ~b;
            OP_MUL8: res = {{(DATA_W-2*MUL_W){1'b0}}, prod};
            OP_MIN:  res = (a < b) ? a : b;
            OP_MAX:  res = (a < b) ? b : a;
            OP_CMP:  res = {{(DATA_W-8){1'b0}}, cmp_code};
            OP_MSB:  res = {{(DATA_W-IDX_W){1'b0}}, top_idx};
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/cp_alu.sv
module cp_alu
    import cpalu_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16,
    parameter int MUL_W  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               valid_i,
    input  logic [INSTR_W-1:0] instr_i,
    input  logic [DATA_W-1:0]  src1_i,
    input  logic [DATA_W-1:0]  src2_i,
    output logic [DATA_W-1:0]  result_o,
    output logic               result_valid_o,
    output logic               carry_o
);
    alu_op_e           op;
    logic [DATA_W-1:0] opb;
    logic [DATA_W-1:0] arith_res;
    logic [DATA_W-1:0] shift_res;
    logic [DATA_W-1:0] misc_res;
    logic [DATA_W-1:0] next_res;
    logic              next_carry;

    cpalu_decode #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_dec (
        .instr (instr_i),
        .src2  (src2_i),
        .op    (op),
        .opb   (opb)
    );

    cpalu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .op   (op),
        .a    (src1_i),
        .b    (opb),
        .cin  (carry_o),
        .sum  (arith_res),
        .cout (next_carry)
    );

    cpalu_shift #(.DATA_W(DATA_W)) u_shift (
        .op  (op),
        .a   (src1_i),
        .b   (opb),
        .res (shift_res)
    );

    cpalu_misc #(.DATA_W(DATA_W), .MUL_W(MUL_W)) u_misc (
        .op  (op),
        .a   (src1_i),
        .b   (opb),
        .res (misc_res)
    );

    always_comb begin
        unique case (op)
            OP_ADD, OP_ADDHI, OP_SUB, OP_SUBHI:  next_res = arith_res;
            OP_SHL, OP_USHR, OP_ISHR, OP_ROT:    next_res = shift_res;
            default:                             next_res = misc_res;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result_o       <= '0;
            result_valid_o <= 1'b0;
            carry_o        <= 1'b0;
        end else begin
            result_valid_o <= valid_i;
            if (valid_i) begin
                result_o <= next_res;
                if (writes_carry(op)) carry_o <= next_carry;
            end
        end
    end
endmodule

// File: rtl/cp_alu_checker.sv
module cp_alu_checker
    import cpalu_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic               clk,
    input logic               rst,
    input logic               valid_i,
    input logic [INSTR_W-1:0] instr_i,
    input logic [DATA_W-1:0]  result_o,
    input logic               result_valid_o,
    input logic               carry_o
);
    alu_op_e chk_op;
    assign chk_op = op_of(instr_i);

    a_r1_valid_latency: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (result_valid_o == $past(valid_i)));

    a_r1_result_hold: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> $stable(result_o));

    a_r12_reset_clears: assert property (@(posedge clk)
        rst |=> (!carry_o && !result_valid_o));

    a_r12_carry_kept: assert property (@(posedge clk) disable iff (rst)
        (!valid_i || !(chk_op == OP_ADD || chk_op == OP_SUB)) |=> $stable(carry_o));

    a_r10_cmp_codes: assert property (@(posedge clk) disable iff (rst)
        (valid_i && chk_op == OP_CMP) |=>
            (result_o == 32'h0 || result_o == 32'h2b || result_o == 32'h1e));

    a_r8_mul_width: assert property (@(posedge clk) disable iff (rst)
        (valid_i && chk_op == OP_MUL8) |=> (result_o[DATA_W-1:16] == '0));

    a_r11_msb_range: assert property (@(posedge clk) disable iff (rst)
        (valid_i && chk_op == OP_MSB) |=> (result_o < DATA_W));

    a_r13_bad_zero: assert property (@(posedge clk) disable iff (rst)
        (valid_i && chk_op == OP_BAD) |=> (result_o == '0));
endmodule

bind cp_alu cp_alu_checker #(.DATA_W(DATA_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .valid_i        (valid_i),
    .instr_i        (instr_i),
    .result_o       (result_o),
    .result_valid_o (result_valid_o),
    .carry_o        (carry_o)
);

// File: tb/cp_alu_tb_top.sv
module cp_alu_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [31:0] src1_i = '0;
    logic [31:0] src2_i = '0;
    logic [31:0] result_o;
    logic        result_valid_o;
    logic        carry_o;

    always #10 clk = ~clk;

    cp_alu dut_i (
        .clk(clk), .rst(rst), .valid_i(valid_i), .instr_i(instr_i),
        .src1_i(src1_i), .src2_i(src2_i), .result_o(result_o),
        .result_valid_o(result_valid_o), .carry_o(carry_o)
    );

    typedef struct {
        logic [31:0] res;
        logic        cy;
        string       tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    logic mdl_carry = 1'b0;
    bit   done = 1'b0;

    function automatic logic [31:0] rform(input logic [4:0] code);
        return {5'b10011, 22'd0, code};
    endfunction

    function automatic logic [31:0] iform(input logic [4:0] code, input logic [15:0] imm);
        return {code, 11'd0, imm};
    endfunction

    function automatic string tag_of(input int code);
        case (code)
            1, 2: return "R2";
            3, 4: return "R3";
            5, 6, 7: return "R4";
            8: return "R5";
            9, 10, 11: return "R6";
            12: return "R7";
            13: return "R8";
            14, 15: return "R9";
            16: return "R10";
            20: return "R11";
            default: return "R13";
        endcase
    endfunction

    task automatic drive(input logic [31:0] ins, input logic [31:0] a,
                         input logic [31:0] s2, input string tag);
        exp_t        e;
        logic [31:0] b;
        logic [32:0] w;
        int          code;
        bit          regf;
        regf = (ins[31:27] == 5'b10011);
        code = regf ? int'(ins[4:0]) : int'(ins[31:27]);
        b    = regf ? s2 : {16'd0, ins[15:0]};
        if (!regf && code == 20) code = 0;
        e.res = 32'd0;
        case (code)
            1: begin w = {1'b0, a} + {1'b0, b}; e.res = w[31:0]; mdl_carry = w[32]; end
            2: e.res = a + b + {31'd0, mdl_carry};
            3: begin e.res = a - b; mdl_carry = (a < b); end
            4: e.res = a - b - {31'd0, mdl_carry};
            5: e.res = a & b;
            6: e.res = a | b;
            7: e.res = a ^ b;
            8: e.res = ~b;
            9: for (int k = 0; k < 32; k++)
                   e.res[k] = (k >= int'(b[4:0])) ? a[k - int'(b[4:0])] : 1'b0;
            10: for (int k = 0; k < 32; k++)
                   e.res[k] = (k + int'(b[4:0]) < 32) ? a[k + int'(b[4:0])] : 1'b0;
            11: for (int k = 0; k < 32; k++)
                   e.res[k] = (k + int'(b[4:0]) < 32) ? a[k + int'(b[4:0])] : a[31];
            12: for (int k = 0; k < 32; k++)
                   e.res[k] = a[(k - int'(b[4:0]) + 32) % 32];
            13: e.res = {16'd0, 8'd0, a[7:0]} * {16'd0, 8'd0, b[7:0]};
            14: e.res = (a <= b) ? a : b;
            15: e.res = (a >= b) ? a : b;
            16: e.res = (a == b) ? 32'h2b : ((a < b) ? 32'h1e : 32'h0);
            20: for (int k = 0; k < 32; k++) if (b[k]) e.res = k;
            default: e.res = 32'd0;
        endcase
        e.cy  = mdl_carry;
        e.tag = tag;
        @(negedge clk);
        valid_i = 1'b1;
        instr_i = ins;
        src1_i  = a;
        src2_i  = s2;
        exp_q.push_back(e);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            valid_i = 1'b0;
            instr_i = 32'hDEAD_BEEF;
            src1_i  = 32'h1234_5678;
            src2_i  = 32'h9ABC_DEF0;
        end
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    // Monitor: compares each produced result against the scoreboard head.
    always @(negedge clk) begin
        if (!rst && result_valid_o) begin
            if (exp_q.size() == 0) begin
                check("R1", {31'd0, result_valid_o}, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.tag, result_o, e.res);
                check(e.tag, {31'd0, carry_o}, {31'd0, e.cy});
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12", {31'd0, carry_o}, 32'd0);
        check("R12", {31'd0, result_valid_o}, 32'd0);
        check("R1",  result_o, 32'd0);
        rst = 1'b0;

        // R2: add carry out, 64-bit add
        drive(rform(1), 32'hFFFF_FFFF, 32'h1, "R2");
        drive(rform(2), 32'h5, 32'h6, "R2");
        drive(rform(1), 32'h1, 32'h2, "R2");
        drive(rform(2), 32'h5, 32'h6, "R2");
        drive(rform(1), 32'hFFFF_FFFF, 32'h0000_0001, "R2");
        drive(rform(2), 32'h0000_0001, 32'h0, "R2");
        drive(iform(1, 16'hFFFF), 32'hFFFF_0001, 32'h0, "R2");
        drive(iform(2, 16'h0010), 32'h1, 32'h0, "R2");
        // R3: borrow and 64-bit subtract
        drive(rform(3), 32'h5, 32'h7, "R3");
        drive(rform(4), 32'hA, 32'h3, "R3");
        drive(rform(3), 32'h7, 32'h5, "R3");
        drive(rform(4), 32'hA, 32'h3, "R3");
        drive(iform(3, 16'h0008), 32'h8, 32'h0, "R3");
        drive(iform(4, 16'h0001), 32'h0, 32'h0, "R3");
        // R1: immediate form ignores src2, upper fields ignored
        drive({5'd1, 11'h7FF, 16'h0003}, 32'h10, 32'hFFFF_FFFF, "R1");
        // R4: logic ops and move
        drive(rform(5), 32'hF0F0_1234, 32'h0FF0_FFFF, "R4");
        drive(rform(6), 32'h0, 32'hCAFE_F00D, "R4");
        drive(rform(7), 32'hAAAA_5555, 32'hFFFF_0000, "R4");
        drive(iform(6, 16'h8001), 32'h0100_0000, 32'h0, "R4");
        // R5: not
        drive(rform(8), 32'h1111_1111, 32'h0F0F_0000, "R5");
        drive(iform(8, 16'h00F0), 32'h0, 32'h0, "R5");
        // R6: shifts, amount from low five bits
        drive(rform(9), 32'h0000_0011, 32'd35, "R6");
        drive(rform(10), 32'h8000_0000, 32'd4, "R6");
        drive(rform(11), 32'h8000_0000, 32'd4, "R6");
        drive(rform(11), 32'h4000_0000, 32'd30, "R6");
        drive(iform(9, 16'h0000), 32'h1234_5678, 32'h0, "R6");
        // R7: rotate
        drive(rform(12), 32'h8000_0001, 32'd1, "R7");
        drive(rform(12), 32'h1234_5678, 32'd36, "R7");
        drive(iform(12, 16'd0), 32'hABCD_0001, 32'h0, "R7");
        // R8: multiply low bytes
        drive(rform(13), 32'h1234_56FF, 32'hABCD_EFFF, "R8");
        drive(iform(13, 16'h1203), 32'h0000_0105, 32'h0, "R8");
        // R9: unsigned min/max
        drive(rform(14), 32'hFFFF_FFFF, 32'h1, "R9");
        drive(rform(15), 32'hFFFF_FFFF, 32'h1, "R9");
        drive(iform(14, 16'h0040), 32'h8000_0000, 32'h0, "R9");
        // R10: compare codes
        drive(rform(16), 32'hFFFF_FFFF, 32'h1, "R10");
        drive(rform(16), 32'h42, 32'h42, "R10");
        drive(rform(16), 32'h1, 32'hFFFF_FFFF, "R10");
        drive(iform(16, 16'h0042), 32'h42, 32'h0, "R10");
        // R11: leading one
        drive(rform(20), 32'h0, 32'h0, "R11");
        drive(rform(20), 32'h0, 32'h1, "R11");
        drive(rform(20), 32'h0, 32'h8000_0000, "R11");
        drive(rform(20), 32'h0, 32'h0001_2345, "R11");
        // R13: undefined ops, carry set first so preservation is visible
        drive(rform(1), 32'hFFFF_FFFF, 32'h2, "R2");
        drive(rform(0), 32'h5, 32'h6, "R13");
        drive(rform(17), 32'h5, 32'h6, "R13");
        drive(rform(31), 32'h5, 32'h6, "R13");
        drive(iform(0, 16'h1234), 32'h5, 32'h6, "R13");
        drive(iform(20, 16'h0001), 32'h5, 32'h6, "R13");
        drive(rform(2), 32'h0, 32'h0, "R13");
        // R12: flag untouched by idle cycles
        idle(5);
        check("R12", {31'd0, carry_o}, {31'd0, mdl_carry});
        drive(rform(4), 32'h10, 32'h0, "R12");
        idle(2);
        check("R1", result_o, 32'hF);

        // mixed sweep across every defined code
        begin
            logic [31:0] lf;
            int          codes[17];
            lf = 32'hACE1_2468;
            for (int i = 0; i < 16; i++) codes[i] = i + 1;
            codes[16] = 20;
            for (int n = 0; n < 400; n++) begin
                logic [31:0] x, y;
                int          c;
                lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
                x  = lf * 32'h9E37_79B9;
                y  = {lf[15:0], lf[31:16]} ^ 32'h5A5A_0F0F;
                c  = codes[n % 17];
                if (n % 3 == 0 && c != 20)
                    drive(iform(5'(c), y[15:0]), x, y, tag_of(c));
                else
                    drive(rform(5'(c)), x, y, tag_of(c));
            end
        end
        idle(4);
        check("R1", exp_q.size(), 32'd0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL R1: watchdog expired, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule